// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is a bank of general-purpose pins behind a small register port. Software picks, pin by pin, whether the pad is driven and at what level. It can read back the level seen on every pad. It can also arm an interrupt on each pin.

Each pin's trigger is chosen by two configuration bits, a kind bit and a sense bit. Together they select one of four triggers: rising edge, falling edge, high level or low level. An edge sets a sticky pending bit, which software clears by writing a one to the acknowledge register. A level condition shows as pending only while the pad holds that level.

A per-pin enable decides whether a pin can become pending at all. A per-pin mask hides a pending pin from the masked status view and from the single combined interrupt line. Pad inputs cross into the clock domain through a two-stage synchronizer. Every trigger decision and every readback uses the synchronized level.

Top module: `pinbank_irq_port`

## Requirements
- R1: A write to offset 0x04 loads the drive-enable register; one bit per pin, 1 makes `pin_oe` high for that pin (output), 0 leaves it an input.
- R2: A write to offset 0x00 loads the output-level register, whose bits appear on `pin_out` on the clock edge after the write.
- R3: A read of offset 0x50 returns the pad levels of `pin_in` as they stood two clock edges earlier (two-stage synchronizer).
- R4: With enable bit 1, kind bit (offset 0x38) = 1 and sense bit (offset 0x3C) = 1, a 0-to-1 change on the synchronized pin sets that pin's pending bit, and it stays set after the pin returns low.
- R5: With enable 1, kind 1 and sense 0, a 1-to-0 change on the synchronized pin sets the pending bit, and it stays set after the pin returns high.
- R6: With kind 0, the pending bit is 1 exactly while the synchronized pin equals the sense bit (sense 1 = high level, sense 0 = low level) and enable is 1; it is not held.
- R7: A pin whose enable bit (offset 0x30) is 0 never shows as pending, and clearing enable discards a held edge.
- R8: A pin whose mask bit (offset 0x34) is 1 is left out of the masked status (offset 0x40) and out of `irq`; the raw pending view (offset 0x44) still shows it.
- R9: Writing a 1 to a pin's bit at offset 0x4C clears that pin's held edge; a 0 bit leaves it unchanged.
- R10: Writes to offset 0x4C do not change the pending bit of a pin set for a level trigger.
- R11: `irq` is high exactly when any bit of the masked status is 1.
- R12: After reset every register reads zero. A read takes effect on the clock edge that samples `bus_rd`, and unmapped offsets read zero. Writes to the status, raw and pad-level offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; `bus_rdata` updates on that edge |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Registered read data |
| pin_in | input | NPIN | Pad levels from outside |
| pin_out | output | NPIN | Level driven onto each pad |
| pin_oe | output | NPIN | Per-pin drive enable |
| irq | output | 1 | Combined active-high interrupt |

## Verification
The awkward state to reach is a port where held edges and live level conditions are pending together. In that state one edge pin must remain pending after its pad has gone back, and a level pin's pending bit must move on its own. The stimulus configures four pins with all four triggers and walks the pads through a fixed pattern sequence. It then issues acknowledge writes that mix edge and level bits, and writes that carry only zeros. Masking and disabling are applied to this mixed state, and the raw view is compared against the masked one.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 7;

  // Byte offsets of the register map
  typedef enum logic [ADDR_W-1:0] {
    REG_DOUT = 7'h00,
    REG_DIR  = 7'h04,
    REG_IEN  = 7'h30,
    REG_IMSK = 7'h34,
    REG_KIND = 7'h38,
    REG_SENS = 7'h3C,
    REG_STAT = 7'h40,
    REG_RAW  = 7'h44,
    REG_ACK  = 7'h4C,
    REG_PAD  = 7'h50
  } reg_ofs_e;
endpackage

// File: rtl/pinbank_rst_sync.sv
module pinbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] st_d;
      if (s == 0) begin : g_first
        always_comb st_d = d;
      end else begin : g_next
        always_comb st_d = st_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[s] <= '0;
        else        st_q[s] <= st_d;
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   raw,
  input  logic [NPIN-1:0]   stat,
  input  logic [NPIN-1:0]   pad,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   dout_q,
  output logic [NPIN-1:0]   en_q,
  output logic [NPIN-1:0]   msk_q,
  output logic [NPIN-1:0]   kind_q,
  output logic [NPIN-1:0]   sens_q,
  output logic [NPIN-1:0]   ack,
  output logic [NPIN-1:0]   rdata
);
  logic [NPIN-1:0] dir_d, dout_d, en_d, msk_d, kind_d, sens_d;
  logic [NPIN-1:0] rmux, rdata_q, rdata_d;

  // next-state: each register has its own load enable
  always_comb begin
    dir_d  = dir_q;
    dout_d = dout_q;
    en_d   = en_q;
    msk_d  = msk_q;
    kind_d = kind_q;
    sens_d = sens_q;
    ack    = '0;
    if (wr) begin
      case (addr)
        REG_DIR:  dir_d  = wdata;
        REG_DOUT: dout_d = wdata;
        REG_IEN:  en_d   = wdata;
        REG_IMSK: msk_d  = wdata;
        REG_KIND: kind_d = wdata;
        REG_SENS: sens_d = wdata;
        REG_ACK:  ack    = wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      REG_DIR:  rmux = dir_q;
      REG_DOUT: rmux = dout_q;
      REG_IEN:  rmux = en_q;
      REG_IMSK: rmux = msk_q;
      REG_KIND: rmux = kind_q;
      REG_SENS: rmux = sens_q;
      REG_STAT: rmux = stat;
      REG_RAW:  rmux = raw;
      REG_PAD:  rmux = pad;
      default:  rmux = '0;
    endcase
    rdata_d = rd ? rmux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dout_q  <= '0;
      en_q    <= '0;
      msk_q   <= '0;
      kind_q  <= '0;
      sens_q  <= '0;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      dout_q  <= dout_d;
      en_q    <= en_d;
      msk_q   <= msk_d;
      kind_q  <= kind_d;
      sens_q  <= sens_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pinbank_trig.sv
module pinbank_trig #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] en,
  input  logic [NPIN-1:0] kind,
  input  logic [NPIN-1:0] sens,
  input  logic [NPIN-1:0] msk,
  input  logic [NPIN-1:0] ack,
  output logic [NPIN-1:0] edge_hit,
  output logic [NPIN-1:0] held,
  output logic [NPIN-1:0] raw,
  output logic [NPIN-1:0] stat,
  output logic            irq
);
  logic [NPIN-1:0] prev_q, held_q, held_d;

  generate
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
      logic rise, fall, lvl_ok;
      always_comb begin
        rise        = lvl[g] & ~prev_q[g];
        fall        = ~lvl[g] & prev_q[g];
        edge_hit[g] = kind[g] & (sens[g] ? rise : fall);
        // a new edge wins over an acknowledge in the same cycle
        held_d[g]   = en[g] & kind[g] & (edge_hit[g] | (held_q[g] & ~ack[g]));
        lvl_ok      = ~(lvl[g] ^ sens[g]);
        raw[g]      = en[g] & (kind[g] ? held_q[g] : lvl_ok);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      held_q <= '0;
    end else begin
      prev_q <= lvl;
      held_q <= held_d;
    end
  end

  assign held = held_q;
  assign stat = raw & ~msk;
  assign irq  = |stat;
endmodule

// File: rtl/pinbank_irq_port.sv
module pinbank_irq_port
  import pinbank_pkg::*;
#(
  parameter int NPIN      = 32,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  logic            core_rst_n;
  logic [NPIN-1:0] pad_s, en_q, msk_q, kind_q, sens_q, ack;
  logic [NPIN-1:0] raw_st, msk_st, edge_hit, held;

  pinbank_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  pinbank_sync #(.W(NPIN), .STAGES(SYNC_LEN)) sync_i (
    .clk(clk), .rst_n(core_rst_n), .d(pin_in), .q(pad_s)
  );

  pinbank_regs #(.NPIN(NPIN)) regs_i (
    .clk(clk), .rst_n(core_rst_n), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .raw(raw_st), .stat(msk_st),
    .pad(pad_s), .dir_q(pin_oe), .dout_q(pin_out), .en_q(en_q),
    .msk_q(msk_q), .kind_q(kind_q), .sens_q(sens_q), .ack(ack),
    .rdata(bus_rdata)
  );

  pinbank_trig #(.NPIN(NPIN)) trig_i (
    .clk(clk), .rst_n(core_rst_n), .lvl(pad_s), .en(en_q), .kind(kind_q),
    .sens(sens_q), .msk(msk_q), .ack(ack), .edge_hit(edge_hit),
    .held(held), .raw(raw_st), .stat(msk_st), .irq(irq)
  );
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
  import pinbank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [NPIN-1:0]   wdata,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   en,
  input logic [NPIN-1:0]   kind,
  input logic [NPIN-1:0]   msk,
  input logic [NPIN-1:0]   edge_hit,
  input logic [NPIN-1:0]   held,
  input logic [NPIN-1:0]   raw,
  input logic              irq
);
  logic            ack_w;
  logic [NPIN-1:0] ack_bits;
  assign ack_w    = wr && (addr == REG_ACK);
  assign ack_bits = ack_w ? wdata : '0;

  // R1
  dir_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_DIR) |=> (pin_oe == $past(wdata)));

  // R2
  dout_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_DOUT) |=> (pin_out == $past(wdata)));

  // R4 R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(held & en & kind & ~ack_bits) & en & kind & ~held) == '0));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> ((held & $past(wdata) & ~$past(edge_hit)) == '0));

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~en) == '0));

  // R8 R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~msk) == '0) |-> !irq);
endmodule

bind pinbank_irq_port pinbank_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst_n(core_rst_n), .wr(bus_wr), .addr(bus_addr),
  .wdata(bus_wdata), .pin_oe(pin_oe), .pin_out(pin_out), .en(en_q),
  .kind(kind_q), .msk(msk_q), .edge_hit(edge_hit), .held(held),
  .raw(raw_st), .irq(irq)
);

// File: tb/pinbank_irq_port_tb_top.sv
module pinbank_irq_port_tb_top;
  import pinbank_pkg::*;
  localparam int NPIN = 32;

  typedef struct {
    logic [NPIN-1:0] exp;
    string           tag;
  } sb_item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [NPIN-1:0]   bus_wdata = '0;
  logic [NPIN-1:0]   bus_rdata;
  logic [NPIN-1:0]   pin_in = '0;
  logic [NPIN-1:0]   pin_out, pin_oe;
  logic              irq;

  int       n_chk = 0;
  int       n_fail = 0;
  bit       done = 1'b0;
  sb_item_t sb_q[$];

  always #5 clk = ~clk;

  pinbank_irq_port #(.NPIN(NPIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [NPIN-1:0] act,
                       input logic [NPIN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [NPIN-1:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issue a read and push what it must return
  task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [NPIN-1:0] v,
                        input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = v; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compare each read result one step after its edge
  initial begin
    forever begin
      logic rv;
      sb_item_t it;
      @(posedge clk);
      rv = bus_rd;
      #1;
      if (rv) begin
        if (sb_q.size() == 0) check("SB underflow", '1, '0);
        else begin
          it = sb_q.pop_front();
          check(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R12 reset state
    rd_exp(REG_DIR,  '0, "R12 dir reset");
    rd_exp(REG_DOUT, '0, "R12 dout reset");
    rd_exp(REG_IEN,  '0, "R12 enable reset");
    rd_exp(REG_RAW,  '0, "R12 raw reset");
    idle(1);
    check("R12 irq reset", {31'd0, irq}, '0);
    check("R12 oe reset", pin_oe, '0);

    // R1 R2 drive path
    wr_reg(REG_DIR, 32'h0000_FFFF);
    wr_reg(REG_DOUT, 32'hA5A5_1234);
    idle(1);
    check("R1 pin_oe", pin_oe, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'hA5A5_1234);
    rd_exp(REG_DIR, 32'h0000_FFFF, "R1 dir readback");
    rd_exp(REG_DOUT, 32'hA5A5_1234, "R2 dout readback");

    // R3 pad readback
    pin_in = 32'hDEAD_BEEF;
    idle(3);
    rd_exp(REG_PAD, 32'hDEAD_BEEF, "R3 pad level");
    pin_in = '0;
    idle(3);
    rd_exp(REG_PAD, 32'h0, "R3 pad level low");

    // pin0 rising, pin1 falling, pin2 high level, pin3 low level
    wr_reg(REG_KIND, 32'h3);
    wr_reg(REG_SENS, 32'h5);
    wr_reg(REG_IEN, 32'hF);
    idle(1);
    rd_exp(REG_RAW, 32'h8, "R6 low level active");
    idle(1);
    check("R11 irq on low level", {31'd0, irq}, 32'h1);

    pin_in = 32'h7;
    idle(4);
    rd_exp(REG_RAW, 32'hD, "R4 rising held + R6 high level");

    pin_in = 32'h8;
    idle(4);
    rd_exp(REG_RAW, 32'h3, "R4 held after fall + R5 falling");

    wr_reg(REG_ACK, 32'h1);
    rd_exp(REG_RAW, 32'h2, "R9 ack clears pin0");
    wr_reg(REG_ACK, 32'h0);
    rd_exp(REG_RAW, 32'h2, "R9 zero ack no effect");

    wr_reg(REG_IMSK, 32'h2);
    rd_exp(REG_STAT, 32'h0, "R8 masked status");
    rd_exp(REG_RAW, 32'h2, "R8 raw unmasked");
    idle(1);
    check("R8 irq masked", {31'd0, irq}, 32'h0);
    wr_reg(REG_IMSK, 32'h0);
    idle(1);
    check("R11 irq unmasked", {31'd0, irq}, 32'h1);
    wr_reg(REG_ACK, 32'h2);
    idle(1);
    check("R11 irq after ack", {31'd0, irq}, 32'h0);
    rd_exp(REG_STAT, 32'h0, "R9 pin1 cleared");

    // R10 level pins ignore ack
    pin_in = 32'h4;
    idle(4);
    rd_exp(REG_RAW, 32'hC, "R10 both levels active");
    wr_reg(REG_ACK, 32'hC);
    rd_exp(REG_RAW, 32'hC, "R10 ack on level pins");

    // R7 enable gating, held edge discarded
    pin_in = 32'h5;
    idle(4);
    rd_exp(REG_RAW, 32'hD, "R4 second rising");
    wr_reg(REG_IEN, 32'h0);
    rd_exp(REG_RAW, 32'h0, "R7 disabled");
    idle(1);
    check("R7 irq disabled", {31'd0, irq}, 32'h0);
    wr_reg(REG_IEN, 32'h1);
    rd_exp(REG_RAW, 32'h0, "R7 held edge dropped");

    // R12 read-only offsets and unmapped offset
    wr_reg(REG_RAW, '1);
    wr_reg(REG_STAT, '1);
    wr_reg(REG_PAD, '1);
    rd_exp(REG_RAW, 32'h0, "R12 raw read-only");
    rd_exp(REG_PAD, 32'h5, "R12 pad read-only");
    rd_exp(7'h20, 32'h0, "R12 unmapped reads zero");

    wait (sb_q.size() == 0);
    idle(3);
    finish_run();
  end
endmodule